// File: doc/BRIEF.md
# Hash-Steered Row Switch

This block is the steering stage in front of a bank of hash-join processing units. Four input channels each offer one row per cycle. A row is a key, a payload and a hash that was computed upstream. The block reads the top bits of each row's hash and sends the row to one of eight output queues. Each queue feeds one processing unit, and that unit keeps its own private storage bank. Rows for different units therefore never compete for the same bank.

Two or more channels may aim at the same unit in the same cycle. A round-robin arbiter for that output then admits one of them, and the other channels hold their rows. Each output has a small queue with a ready/valid interface. Once every input channel has signalled that its data is finished and every queue has emptied, an end-of-data flag is raised on all eight outputs.

Top module: `hash_row_switch`

## Requirements
- R1: A row goes to the output whose index equals the three most significant bits of its hash, `hash[HASH_W-1 -: 3]`. No row appears on any other output.
- R2: The key and the payload of a row come out together at the chosen output, and neither is changed.
- R3: Each output has its own round-robin arbiter. After reset its pointer is at channel 0. The grant goes to the first requesting channel at or after the pointer, in cyclic order. After a row is accepted, the pointer moves to the channel just after the granted one.
- R4: A channel that loses arbitration sees `in_ready` low. It keeps offering the same row, and that row is delivered later.
- R5: Rows from one channel that are bound for the same output leave that output in the order they were accepted.
- R6: While an output queue holds `DEPTH` rows, every channel that targets it sees `in_ready` low, and the queue never overflows.
- R7: `out_eod` stays low until two conditions are both met: every channel has pulsed `in_eod`, and every output queue is empty. After that, all bits of `out_eod` go high and stay high until reset.
- R8: While `rst` is high, `out_valid` and `out_eod` are all zero.
- R9: A row accepted into an empty queue appears with `out_valid` high on the cycle after the accepting clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | NUM_CH | Row offered on each channel |
| in_ready | output | NUM_CH | Row accepted on each channel this cycle |
| in_hash | input | NUM_CH*HASH_W | Hash of each channel's row |
| in_key | input | NUM_CH*KEY_W | Key of each channel's row |
| in_pay | input | NUM_CH*PAY_W | Payload of each channel's row |
| in_eod | input | NUM_CH | One-cycle pulse: this channel has no more rows |
| out_valid | output | NUM_PU | Row available at each output |
| out_ready | input | NUM_PU | Processing unit takes the row |
| out_key | output | NUM_PU*KEY_W | Key at each output |
| out_pay | output | NUM_PU*PAY_W | Payload at each output |
| out_eod | output | NUM_PU | End of data, broadcast to every unit |

## Verification
The hardest situation to reach is an arbiter that must resume from a pointer that is not at zero while its queue has just gone from full to not full. Random traffic almost never lines up four channels on one output while that output is stalled.

The bench creates this case directly. It blocks one output and aims all four channels at it until the queue fills. It then checks that the remaining rows stall and that, once the output drains, they are admitted in rotation order.

A second directed step moves one output's pointer to channel 3, then offers rows from channels 0 and 3 together. This checks that the pointer passes over channels that are not requesting. The end-of-data flag is tested separately. All channels finish while one queue still holds rows, and the flag must not rise until that queue has drained.

// File: rtl/rsw_pkg.sv
package rsw_pkg;
  localparam int RSW_NUM_CH = 4;
  localparam int RSW_NUM_PU = 8;
  localparam int RSW_HASH_W = 8;
  localparam int RSW_KEY_W  = 16;
  localparam int RSW_PAY_W  = 16;
  localparam int RSW_DEPTH  = 4;
endpackage

// File: rtl/rsw_rr_arb.sv
module rsw_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] grant
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr;
  logic [IW-1:0] gidx;
  logic          hit;

  always_comb begin
    int idx;
    grant = '0;
    gidx  = '0;
    hit   = 1'b0;
    for (int i = 0; i < N; i++) begin
      idx = (int'(ptr) + i) % N;
      if (!hit && req[idx]) begin
        hit  = 1'b1;
        gidx = IW'(idx);
      end
    end
    if (hit) grant[gidx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (adv && hit) ptr <= (gidx == IW'(N-1)) ? '0 : gidx + 1'b1;
  end

  assert_one_grant_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  assert_rotates_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && hit) |=> (((req & ~$past(grant)) == '0) || (grant != $past(grant))));
endmodule

// File: rtl/rsw_queue.sv
module rsw_queue #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/hash_row_switch.sv
module hash_row_switch
  import rsw_pkg::*;
#(
  parameter int NUM_CH = RSW_NUM_CH,
  parameter int NUM_PU = RSW_NUM_PU,
  parameter int HASH_W = RSW_HASH_W,
  parameter int KEY_W  = RSW_KEY_W,
  parameter int PAY_W  = RSW_PAY_W,
  parameter int DEPTH  = RSW_DEPTH
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_CH-1:0]          in_valid,
  output logic [NUM_CH-1:0]          in_ready,
  input  logic [NUM_CH*HASH_W-1:0]   in_hash,
  input  logic [NUM_CH*KEY_W-1:0]    in_key,
  input  logic [NUM_CH*PAY_W-1:0]    in_pay,
  input  logic [NUM_CH-1:0]          in_eod,
  output logic [NUM_PU-1:0]          out_valid,
  input  logic [NUM_PU-1:0]          out_ready,
  output logic [NUM_PU*KEY_W-1:0]    out_key,
  output logic [NUM_PU*PAY_W-1:0]    out_pay,
  output logic [NUM_PU-1:0]          out_eod
);
  localparam int SEL_W = (NUM_PU > 1) ? $clog2(NUM_PU) : 1;
  localparam int ROW_W = KEY_W + PAY_W;

  logic [SEL_W-1:0]  dest [NUM_CH];
  logic [NUM_CH-1:0] gnt  [NUM_PU];
  logic [NUM_PU-1:0] full, empty, push;
  logic [NUM_CH-1:0] done_seen;
  logic              eod_r;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dest
    assign dest[c] = in_hash[c*HASH_W + HASH_W - 1 -: SEL_W];
  end

  for (genvar p = 0; p < NUM_PU; p++) begin : g_pu
    logic [NUM_CH-1:0] req;
    logic [ROW_W-1:0]  wdata, rdata;

    always_comb begin
      for (int c = 0; c < NUM_CH; c++)
        req[c] = in_valid[c] && (dest[c] == SEL_W'(p));
    end

    rsw_rr_arb #(.N(NUM_CH)) i_arb (
      .clk   (clk),
      .rst   (rst),
      .req   (req),
      .adv   (!full[p]),
      .grant (gnt[p])
    );

    always_comb begin
      wdata = '0;
      for (int c = 0; c < NUM_CH; c++)
        if (gnt[p][c]) wdata = {in_key[c*KEY_W +: KEY_W], in_pay[c*PAY_W +: PAY_W]};
    end

    assign push[p] = (|gnt[p]) && !full[p];

    rsw_queue #(.W(ROW_W), .DEPTH(DEPTH)) i_q (
      .clk   (clk),
      .rst   (rst),
      .push  (push[p]),
      .din   (wdata),
      .pop   (out_valid[p] && out_ready[p]),
      .dout  (rdata),
      .full  (full[p]),
      .empty (empty[p])
    );

    assign out_valid[p]                 = !empty[p];
    assign out_key[p*KEY_W +: KEY_W]    = rdata[ROW_W-1 -: KEY_W];
    assign out_pay[p*PAY_W +: PAY_W]    = rdata[PAY_W-1:0];

    assert_push_visible_R9: assert property (@(posedge clk) disable iff (rst)
      push[p] |=> out_valid[p]);
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      in_ready[c] = 1'b0;
      for (int p = 0; p < NUM_PU; p++)
        if (gnt[p][c] && !full[p]) in_ready[c] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_seen <= '0;
      eod_r     <= 1'b0;
    end else begin
      done_seen <= done_seen | in_eod;
      if ((&done_seen) && (&empty) && !(|in_valid)) eod_r <= 1'b1;
    end
  end

  assign out_eod = {NUM_PU{eod_r}};

  assert_eod_after_all_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(eod_r) |-> (&done_seen));

  assert_eod_drained_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(eod_r) |-> !(|out_valid));

  assert_ready_one_dest_R4: assert property (@(posedge clk) disable iff (rst)
    (in_ready & ~in_valid) == '0);
endmodule

// File: tb/test_hash_row_switch.sv
module test_hash_row_switch;
  localparam int NCH = 4, NPU = 8, HW = 8, KW = 16, PW = 16, DEPTH = 4, SW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                 rst;
  logic [NCH-1:0]       in_valid, in_ready, in_eod;
  logic [NCH*HW-1:0]    in_hash;
  logic [NCH*KW-1:0]    in_key;
  logic [NCH*PW-1:0]    in_pay;
  logic [NPU-1:0]       out_valid, out_ready, out_eod;
  logic [NPU*KW-1:0]    out_key;
  logic [NPU*PW-1:0]    out_pay;

  hash_row_switch #(.NUM_CH(NCH), .NUM_PU(NPU), .HASH_W(HW), .KEY_W(KW),
                    .PAY_W(PW), .DEPTH(DEPTH)) i_hash_row_switch (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_hash(in_hash), .in_key(in_key), .in_pay(in_pay), .in_eod(in_eod),
    .out_valid(out_valid), .out_ready(out_ready), .out_key(out_key),
    .out_pay(out_pay), .out_eod(out_eod));

  int n_chk = 0, n_fail = 0, serial = 0;
  bit finished = 0;

  bit             cv [NCH];
  logic [HW-1:0]  chs[NCH];
  logic [KW-1:0]  ck [NCH];
  logic [PW-1:0]  cp [NCH];
  bit             acc[NCH];
  logic [NCH-1:0] eod_v = '0;
  logic [KW+PW-1:0] expq [NPU][$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic load(input int c, input logic [HW-1:0] h);
    cv[c]  = 1'b1;
    chs[c] = h;
    ck[c]  = {4'(c), 12'(serial)};
    cp[c]  = 16'($urandom);
    serial++;
  endtask

  task automatic step();
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      in_valid[c]          = cv[c];
      in_hash[c*HW +: HW]  = chs[c];
      in_key[c*KW +: KW]   = ck[c];
      in_pay[c*PW +: PW]   = cp[c];
    end
    in_eod = eod_v;
    #1;
    for (int c = 0; c < NCH; c++) begin
      acc[c] = cv[c] && in_ready[c];
      if (acc[c]) expq[chs[c][HW-1 -: SW]].push_back({ck[c], cp[c]});
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Monitor: compares each delivered row with the scoreboard queue of its output
  always @(negedge clk) begin
    #2;
    if (!rst) begin
      for (int p = 0; p < NPU; p++) begin
        if (out_valid[p] && out_ready[p]) begin
          logic [KW+PW-1:0] got;
          got = {out_key[p*KW +: KW], out_pay[p*PW +: PW]};
          if (expq[p].size() == 0) chk(0, "R1 row on wrong output", got, 0);
          else begin
            chk(got == expq[p][0], "R2 R5 row content or order", got, expq[p][0]);
            void'(expq[p].pop_front());
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired got=0 exp=1");
    summary();
  end

  initial begin
    int ord[$];
    int sent[NCH];
    int w;
    bit busy;
    rst = 1'b1; in_valid = '0; in_eod = '0; in_hash = '0; in_key = '0; in_pay = '0;
    out_ready = '1;
    for (int c = 0; c < NCH; c++) begin cv[c] = 0; chs[c] = '0; ck[c] = '0; cp[c] = '0; sent[c] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(out_valid == '0, "R8 reset out_valid", out_valid, 0);
    chk(out_eod == '0, "R8 reset out_eod", out_eod, 0);
    rst = 1'b0;

    // R9: single row to output 3
    load(1, 8'b011_10101);
    step();
    chk(acc[1], "R9 row accepted", acc[1], 1);
    cv[1] = 0;
    step();
    chk(out_valid == 8'h08, "R9 one-cycle latency R1 routing", out_valid, 8'h08);
    repeat (3) step();

    // R3: four channels on output 0 with output 0 blocked
    out_ready = 8'hFE;
    for (int c = 0; c < NCH; c++) load(c, {3'd0, 5'($urandom)});
    for (int s = 0; s < 4; s++) begin
      step();
      for (int c = 0; c < NCH; c++) if (acc[c]) begin ord.push_back(c); cv[c] = 0; end
    end
    chk(ord.size() == 4, "R3 one grant per cycle", ord.size(), 4);
    for (int i = 0; i < ord.size(); i++) chk(ord[i] == i, "R3 rotation order", ord[i], i);

    // R6: queue full, all channels stall
    for (int c = 0; c < NCH; c++) load(c, {3'd0, 5'($urandom)});
    step(); step();
    chk(!(acc[0] || acc[1] || acc[2] || acc[3]), "R6 full queue stalls inputs", in_ready, 0);

    // R4: release; held rows enter in rotation
    out_ready = '1;
    ord.delete();
    for (int s = 0; s < 12 && ord.size() < 4; s++) begin
      step();
      for (int c = 0; c < NCH; c++) if (acc[c]) begin ord.push_back(c); cv[c] = 0; end
    end
    chk(ord.size() == 4, "R4 stalled rows delivered", ord.size(), 4);
    for (int i = 0; i < ord.size(); i++) chk(ord[i] == i, "R3 R4 rotation after stall", ord[i], i);
    repeat (6) step();

    // R3: pointer skips channels that are not requesting
    load(2, {3'd6, 5'd1});
    step();
    chk(acc[2], "R3 lone request granted", acc[2], 1);
    cv[2] = 0;
    load(0, {3'd6, 5'd2});
    load(3, {3'd6, 5'd3});
    step();
    chk(acc[3] && !acc[0], "R3 grant after pointer", {acc[3], acc[0]}, 2'b10);
    cv[3] = 0;
    step();
    chk(acc[0], "R3 second requester granted", acc[0], 1);
    cv[0] = 0;
    repeat (4) step();

    // R5 and R1: random traffic with random back-pressure
    busy = 1;
    while (busy) begin
      busy = 0;
      for (int c = 0; c < NCH; c++) begin
        if (!cv[c] && sent[c] < 40) begin
          load(c, (c == 2) ? {3'd5, 5'($urandom)} : 8'($urandom));
          sent[c]++;
        end
        if (cv[c] || sent[c] < 40) busy = 1;
      end
      out_ready = 8'($urandom);
      step();
      for (int c = 0; c < NCH; c++) if (acc[c]) cv[c] = 0;
    end
    out_ready = '1;
    repeat (12) step();
    for (int p = 0; p < NPU; p++)
      chk(expq[p].size() == 0, "R2 every row delivered", expq[p].size(), 0);

    // R7: end of data only after all done and drained
    out_ready = 8'hFB;
    load(0, {3'd2, 5'd7}); step(); cv[0] = 0;
    load(1, {3'd2, 5'd9}); step(); cv[1] = 0;
    eod_v = 4'b0111; step(); eod_v = '0;
    repeat (2) step();
    chk(out_eod == '0, "R7 low with one channel open", out_eod, 0);
    eod_v = 4'b1000; step(); eod_v = '0;
    repeat (3) step();
    chk(out_eod == '0, "R7 low while queue holds rows", out_eod, 0);
    out_ready = '1;
    w = 0;
    while (out_eod != '1 && w < 20) begin step(); w++; end
    chk(out_eod == '1, "R7 raised after drain", out_eod, 8'hFF);
    chk(out_valid == '0, "R7 queues empty at end", out_valid, 0);
    repeat (3) step();
    chk(out_eod == '1, "R7 stays high", out_eod, 8'hFF);
    summary();
  end
endmodule